// File: doc/BRIEF.md
# Programmable Interval Timer Channel, Rate Generator Mode

This block is one channel of a programmable interval timer that is programmed over a byte-wide write interface. A control strobe takes a packed control word. A data strobe takes the 16-bit count, sent as two bytes with the low byte first. Once the count is complete, the channel runs as a rate generator. It divides its counting clock by the count and holds its output high, except for a single low clock once in every period. The output suits a periodic tick interrupt source.

The counting clock is a clock enable, `tick_i`, sampled on the system clock. Counting is binary only. Every control word addressed to the channel sets up the same behaviour: low-then-high count loading and reloading rate generation. The mode and number-format fields of the control word are not decoded. The gate is treated as permanently high, so no gate pin exists.

Top module: `pit_rate_chan`

## Requirements
- R1: After reset, `out_o` is high and the channel is idle (no low pulses) until a count has been loaded.
- R2: A control word is accepted when bits 7:6 equal `CHAN_ID` (default 00) and bits 5:4 are not 00. Accepting it stops counting, drives `out_o` high on the next clock and makes the next data write the low byte. Bits 3:0 are not decoded; for example, 0x34 is accepted.
- R3: A control word with a different channel code in bits 7:6, or with 00 in bits 5:4, is ignored. A running count continues with unchanged timing.
- R4: After a control word, the first data write is the low count byte and the second is the high byte. Counting starts on the clock after the high byte is written. A lone low byte starts nothing.
- R5: With `tick_i` high on every clock and a count N ≥ 2 loaded on clock edge k, `out_o` is low for exactly one clock after edges k+N-1, k+2N-1, and so on, and high at all other times.
- R6: A count of 0 acts as 65536: the first low pulse follows edge k+65535.
- R7: A new count written while the channel is counting does not change the current period. It is used from the next reload on.
- R8: A clock on which `tick_i` is low does not advance the counter, so each such clock delays the next pulse by one clock.
- R9: A count of 1 never produces a low pulse; `out_o` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control word write strobe |
| data_we_i | input | 1 | Count byte write strobe |
| wdata_i | input | DW (8) | Write data for both strobes |
| tick_i | input | 1 | Counting clock enable |
| out_o | output | 1 | Rate generator output, low for one tick per period |

## Verification
The hardest situation to reach is a count replaced during a live period. The new value must land after the reload that ends the current period has already taken the old value, and it must then govern every later period. The stimulus loads a count of 10 and waits past the first pulse. It then writes a count of 4 so that the high byte arrives just after that reload. The scoreboard expects one more period of 10, followed by periods of 4. A similar timed window drops `tick_i` for three clocks in the middle of a period, which shifts every later expected pulse by three.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef struct packed {
    logic [1:0] chan;
    logic [1:0] access;
    logic [2:0] mode;
    logic       bcd;
  } pit_ctrl_t;

  localparam logic [1:0] ACC_LATCH = 2'b00;
endpackage

// File: rtl/pit_ctrl_dec.sv
module pit_ctrl_dec
  import pit_pkg::*;
#(
  parameter int unsigned CHAN_ID = 0
) (
  input  logic       ctrl_we_i,
  input  logic [7:0] wdata_i,
  output logic       arm_clr_o
);
  pit_ctrl_t cw;
  assign cw = pit_ctrl_t'(wdata_i);

  // mode and number format are fixed: rate generator, binary
  logic unused_fields;
  assign unused_fields = ^{cw.mode, cw.bcd};

  assign arm_clr_o = ctrl_we_i && (cw.chan == 2'(CHAN_ID)) && (cw.access != ACC_LATCH);
endmodule

// File: rtl/pit_load_seq.sv
module pit_load_seq #(
  parameter int unsigned DW = 8,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          data_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic          commit_o,
  output logic [CW-1:0] commit_val_o,
  output logic [CW-1:0] reload_o
);
  localparam int unsigned NB = CW / DW;
  localparam int unsigned PW = (NB > 1) ? $clog2(NB) : 1;

  logic [PW-1:0]          ptr_q;
  logic [NB-1:0][DW-1:0]  stage_q;
  logic [NB-1:0][DW-1:0]  commit_bytes;
  logic [CW-1:0]          reload_q;
  logic                   last_byte;

  assign last_byte = (ptr_q == PW'(NB - 1));
  assign commit_o  = data_we_i && !clr_i && last_byte;

  // the byte being written now replaces its staged slot in the assembled count
  for (genvar b = 0; b < NB; b++) begin : g_bytes
    assign commit_bytes[b] = (ptr_q == PW'(b)) ? wdata_i : stage_q[b];
  end
  assign commit_val_o = commit_bytes;
  assign reload_o     = reload_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q    <= '0;
      stage_q  <= '0;
      reload_q <= '0;
    end else if (clr_i) begin
      ptr_q <= '0;
    end else if (data_we_i) begin
      stage_q[ptr_q] <= wdata_i;
      if (last_byte) begin
        ptr_q    <= '0;
        reload_q <= commit_val_o;
      end else begin
        ptr_q <= ptr_q + PW'(1);
      end
    end
  end

  a_r2_ptr_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (ptr_q == '0));
  a_r7_reload_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_o |=> $stable(reload_q));
endmodule

// File: rtl/pit_down_counter.sv
module pit_down_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          start_i,
  input  logic [CW-1:0] start_val_i,
  input  logic [CW-1:0] reload_i,
  input  logic          tick_i,
  output logic          out_o
);
  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] TWO = CW'(2);

  logic          run_q;
  logic          out_q;
  logic [CW-1:0] cnt_q;

  // zero wraps to all ones on the first decrement, giving a 2**CW period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      out_q <= 1'b1;
      cnt_q <= '0;
    end else if (clr_i) begin
      run_q <= 1'b0;
      out_q <= 1'b1;
    end else if (!run_q) begin
      if (start_i) begin
        cnt_q <= start_val_i;
        run_q <= 1'b1;
      end
    end else if (tick_i) begin
      if (cnt_q == ONE) begin
        cnt_q <= reload_i;
        out_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - ONE;
        if (cnt_q == TWO) out_q <= 1'b0;
      end
    end
  end

  assign out_o = out_q;

  a_r5_low_one_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out_q && tick_i) |=> out_q);
  a_r2_clear_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (out_q && !run_q));
  a_r4_start_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !clr_i) |=> run_q);
  a_r8_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !tick_i && !clr_i) |=> ($stable(cnt_q) && $stable(out_q)));
  a_r1_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> out_q);
endmodule

// File: rtl/pit_rate_chan.sv
module pit_rate_chan #(
  parameter int unsigned CHAN_ID = 0,
  parameter int unsigned DW      = 8,
  parameter int unsigned CW      = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_we_i,
  input  logic          data_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          tick_i,
  output logic          out_o
);
  logic          arm_clr;
  logic          commit;
  logic [CW-1:0] commit_val;
  logic [CW-1:0] reload_val;
  logic [7:0]    cw_byte;

  if (DW >= 8) begin : g_cw_wide
    assign cw_byte = wdata_i[7:0];
  end else begin : g_cw_narrow
    assign cw_byte = 8'(wdata_i);
  end

  pit_ctrl_dec #(.CHAN_ID(CHAN_ID)) u_dec (
    .ctrl_we_i (ctrl_we_i),
    .wdata_i   (cw_byte),
    .arm_clr_o (arm_clr)
  );

  pit_load_seq #(.DW(DW), .CW(CW)) u_load (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (arm_clr),
    .data_we_i    (data_we_i),
    .wdata_i      (wdata_i),
    .commit_o     (commit),
    .commit_val_o (commit_val),
    .reload_o     (reload_val)
  );

  pit_down_counter #(.CW(CW)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (arm_clr),
    .start_i     (commit),
    .start_val_i (commit_val),
    .reload_i    (reload_val),
    .tick_i      (tick_i),
    .out_o       (out_o)
  );
endmodule

// File: tb/sim_pit_rate_chan.sv
`timescale 1ns/1ps
module sim_pit_rate_chan;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ctrl_we = 1'b0;
  logic       data_we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       tick = 1'b1;
  logic       out;

  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  int    exp_q[$];
  string tag_q[$];
  string cur_tag = "R1";
  bit    done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pit_rate_chan u0 (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .ctrl_we_i (ctrl_we),
    .data_we_i (data_we),
    .wdata_i   (wdata),
    .tick_i    (tick),
    .out_o     (out)
  );

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // monitor: every low output sample must match the head of the scoreboard
  always @(negedge clk) begin
    if (rst_ni && !done && out === 1'b0) begin
      if (exp_q.size() == 0) begin
        check(1'b0, cur_tag, "unexpected low pulse at cycle", cyc, -1);
      end else begin
        int    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(cyc == e, t, "pulse cycle", cyc, e);
      end
    end
  end

  // driver tasks: entered at a falling edge, return at a falling edge
  task automatic wr_ctrl(input logic [7:0] b);
    ctrl_we = 1'b1; wdata = b;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic wr_data(input logic [7:0] b);
    data_we = 1'b1; wdata = b;
    @(negedge clk);
    data_we = 1'b0;
  endtask

  task automatic load_count(input int n, output int k);
    wr_data(n[7:0]);
    wr_data(n[15:8]);
    k = cyc;
  endtask

  task automatic push_train(input int k, input int n, input int m, input string tag);
    int p;
    p = (n == 0) ? 65536 : n;
    for (int i = 0; i < m; i++) begin
      exp_q.push_back(k + p - 1 + i * p);
      tag_q.push_back(tag);
    end
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic stop_at(input int c, input string tag);
    wait_until(c);
    wr_ctrl(8'h34);
    check(exp_q.size() == 0, tag, "missing pulses", exp_q.size(), 0);
    check(out == 1'b1, tag, "output after stop", int'(out), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual cycle %0d expected below 190000", cyc);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    check(out == 1'b1, "R1", "output in reset", int'(out), 1);
    rst_ni = 1'b1;
    repeat (20) @(negedge clk);
    check(out == 1'b1, "R1", "output idle after reset", int'(out), 1);

    // R5: basic periods
    cur_tag = "R5";
    wr_ctrl(8'h34);
    load_count(5, k);
    push_train(k, 5, 3, "R5");
    stop_at(k + 15, "R5");
    load_count(2, k);
    push_train(k, 2, 4, "R5");
    stop_at(k + 8, "R5");
    load_count(16'h0103, k);
    push_train(k, 16'h0103, 2, "R5");
    stop_at(k + 2 * 16'h0103, "R5");

    // R4: lone low byte starts nothing; high byte starts counting
    cur_tag = "R4";
    wr_data(8'h08);
    repeat (30) @(negedge clk);
    check(out == 1'b1, "R4", "output with only low byte", int'(out), 1);
    wr_data(8'h00);
    k = cyc;
    push_train(k, 8, 2, "R4");
    stop_at(k + 16, "R4");

    // R2: control word resets byte pointer and halts a running count
    cur_tag = "R2";
    wr_data(8'h55);
    wr_ctrl(8'h34);
    load_count(3, k);
    push_train(k, 3, 2, "R2");
    stop_at(k + 6, "R2");
    load_count(50, k);
    wait_until(k + 10);
    wr_ctrl(8'h34);
    check(out == 1'b1, "R2", "output after control word", int'(out), 1);
    repeat (100) @(negedge clk);
    check(exp_q.size() == 0, "R2", "pulses pending after halt", exp_q.size(), 0);

    // R3: foreign channel and latch-code words ignored
    cur_tag = "R3";
    load_count(7, k);
    push_train(k, 7, 3, "R3");
    wait_until(k + 2);
    wr_ctrl(8'h74);
    wr_ctrl(8'h04);
    wr_ctrl(8'hB4);
    stop_at(k + 21, "R3");

    // R7: count replaced just after a reload
    cur_tag = "R7";
    load_count(10, k);
    push_train(k, 10, 2, "R7");
    exp_q.push_back(k + 23); tag_q.push_back("R7");
    exp_q.push_back(k + 27); tag_q.push_back("R7");
    wait_until(k + 12);
    wr_data(8'h04);
    wr_data(8'h00);
    stop_at(k + 28, "R7");

    // R8: three clocks without tick delay the pulse by three
    cur_tag = "R8";
    load_count(6, k);
    exp_q.push_back(k + 8);  tag_q.push_back("R8");
    exp_q.push_back(k + 14); tag_q.push_back("R8");
    @(negedge clk);
    tick = 1'b0;
    repeat (3) @(negedge clk);
    tick = 1'b1;
    stop_at(k + 15, "R8");

    // R9: count of one never pulses
    cur_tag = "R9";
    load_count(1, k);
    repeat (20) @(negedge clk);
    check(out == 1'b1, "R9", "output with count 1", int'(out), 1);
    stop_at(k + 21, "R9");

    // R6: zero means 65536
    cur_tag = "R6";
    load_count(0, k);
    push_train(k, 0, 1, "R6");
    stop_at(k + 65536, "R6");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule